// File: doc/BRIEF.md
# Floating-Point Eight-Bit Immediate Codec

This block translates between a compact eight-bit floating-point constant and the full IEEE-754 single- or double-precision bit pattern that the constant stands for. It also tells whether a full-width pattern can be written as such a constant. A decoder or code generator uses it to materialise small constants, to pack them back into an instruction field, or to decide whether an encoding is legal.

The eight-bit code holds three fields:
- a sign bit in code bit 7;
- an exponent seed bit in code bit 6;
- a six-bit fraction-and-exponent tail in code bits 5..0.

On expansion, the seed is written once inverted and then repeated to fill the upper exponent bits. Everything below the six tail bits is zero.

Each request is captured when `in_valid` is high. Its result appears on registered outputs one cycle later, marked by `out_valid`.

Top module: `fpimm_codec`

## Requirements
- R1: In single mode, the expanded output is laid out as follows: bit 31 is code bit 7; bit 30 is the inverse of code bit 6; bits 29..25 are copies of code bit 6; bits 24..19 are code bits 5..0; bits 18..0 are zero. The code is taken from `in_operand[7:0]`.
- R2: In single mode, bits 63..32 of the expanded output are zero.
- R3: In double mode, the expanded output is laid out as follows: bit 63 is code bit 7; bit 62 is the inverse of code bit 6; bits 61..54 are copies of code bit 6; bits 53..48 are code bits 5..0; bits 47..0 are zero.
- R4: In single mode, the compressed code is built from the operand as follows: code bit 7 is operand bit 31; code bit 6 is operand bit 29; code bits 5..0 are operand bits 24..19.
- R5: In double mode, the compressed code is built from the operand as follows: code bit 7 is operand bit 63; code bit 6 is operand bit 61; code bits 5..0 are operand bits 53..48.
- R6: A single pattern fits only if all three of these hold: bits 18..0 are zero; bits 29..25 are all equal; bit 30 differs from bit 29.
- R7: A double pattern fits only if all three of these hold: bits 47..0 are zero; bits 61..54 are all equal; bit 62 differs from bit 61.
- R8: With operation code 2 (check), or the reserved code 3, `out_fits` reports the fit test. `out_code` is the compressed code when the pattern fits and zero when it does not.
- R9: With operation code 1 (compress), `out_code` is the compressed code whether or not the pattern fits, and `out_fits` reports the fit test.
- R10: With operation code 0 (expand), `out_code` and `out_fits` are both zero.
- R11: `out_valid` is high exactly one cycle after each cycle in which `in_valid` is high. A synchronous reset clears `out_valid` and all outputs. The outputs hold their value while `in_valid` is low.
- R12: In single mode, operand bits 63..32 have no effect on any output.
- R13: For every operation, the expanded output is the expansion of `in_operand[7:0]` in the selected precision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Capture the request this cycle |
| in_dbl | input | 1 | 1 = double precision, 0 = single precision (low 32 bits) |
| in_op | input | 2 | 0 expand, 1 compress, 2 check, 3 reserved (acts as check) |
| in_operand | input | 64 | Full-width pattern; its low eight bits are the code to expand |
| out_valid | output | 1 | Result valid, one cycle after capture |
| out_expanded | output | 64 | Expansion of the operand's low eight bits |
| out_code | output | 8 | Compressed code |
| out_fits | output | 1 | Pattern fits the eight-bit form |

## Verification
All 256 codes are expanded in both precisions; in single mode the operand carries a non-zero upper half. Each expansion is then fed back through a check, which tells a correct exponent run and seed inversion apart from an off-by-one field or a missing inversion, since every expansion must fit and return its own code. Directed non-fitting patterns each break exactly one fit condition: a non-zero low tail, a mixed exponent run, or an equal seed pair. These show that each condition is tested on its own and that a failed check forces the code to zero. Compress on the same patterns must still give the raw code. Idle cycles and reset during a request show that results hold and that `out_valid` tracks `in_valid` exactly.

// File: rtl/fpimm_pkg.sv
`timescale 1ns/1ps
package fpimm_pkg;
  localparam int WORD_W = 64;
  localparam int CODE_W = 8;
  localparam int SP_W   = 32;

  typedef enum logic [1:0] {
    OP_EXPAND   = 2'd0,
    OP_COMPRESS = 2'd1,
    OP_CHECK    = 2'd2,
    OP_RSVD     = 2'd3
  } imm_op_e;
endpackage

// File: rtl/fpimm_lane.sv
`timescale 1ns/1ps
// One precision lane: expansion, compression and fit test for width W.
module fpimm_lane #(
  parameter bit DOUBLE = 1'b0,
  parameter int CODE_W = 8,
  localparam int W     = DOUBLE ? 64 : 32,
  localparam int RUN   = DOUBLE ? 8 : 5,
  localparam int TAIL  = DOUBLE ? 48 : 19,
  localparam int SEED  = W - 3
) (
  input  logic [W-1:0]      word,
  output logic [W-1:0]      expanded,
  output logic [CODE_W-1:0] raw_code,
  output logic              fits
);
  // seed bit sits just below the inverted exponent top bit
  function automatic logic [W-1:0] grow(input logic [CODE_W-1:0] c);
    grow = {c[7], ~c[6], {RUN{c[6]}}, c[5:0], {TAIL{1'b0}}};
  endfunction

  function automatic logic [CODE_W-1:0] shrink(input logic [W-1:0] w);
    shrink = {w[W-1], w[SEED], w[TAIL+5:TAIL]};
  endfunction

  function automatic logic fit_test(input logic [W-1:0] w);
    logic tail_clear, run_even, seed_flip;
    tail_clear = (w[TAIL-1:0] == '0);
    run_even   = (&w[SEED -: RUN]) | ~(|w[SEED -: RUN]);
    seed_flip  = w[W-2] ^ w[SEED];
    fit_test   = tail_clear & run_even & seed_flip;
  endfunction

  assign expanded = grow(word[CODE_W-1:0]);
  assign raw_code = shrink(word);
  assign fits     = fit_test(word);
endmodule

// File: rtl/fpimm_select.sv
`timescale 1ns/1ps
// Applies the operation select to the raw code and fit result.
module fpimm_select
  import fpimm_pkg::*;
(
  input  logic [1:0]        op,
  input  logic [CODE_W-1:0] raw_code,
  input  logic              fits,
  output logic [CODE_W-1:0] code,
  output logic              fits_out
);
  always_comb begin
    unique case (imm_op_e'(op))
      OP_EXPAND: begin
        code     = '0;
        fits_out = 1'b0;
      end
      OP_COMPRESS: begin
        code     = raw_code;
        fits_out = fits;
      end
      default: begin
        code     = fits ? raw_code : '0;
        fits_out = fits;
      end
    endcase
  end
endmodule

// File: rtl/fpimm_outreg.sv
`timescale 1ns/1ps
// Result register with a one-cycle valid.
module fpimm_outreg #(
  parameter int WORD_W = 64,
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] nxt_expanded,
  input  logic [CODE_W-1:0] nxt_code,
  input  logic              nxt_fits,
  output logic              q_valid,
  output logic [WORD_W-1:0] q_expanded,
  output logic [CODE_W-1:0] q_code,
  output logic              q_fits
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid    <= 1'b0;
      q_expanded <= '0;
      q_code     <= '0;
      q_fits     <= 1'b0;
    end else begin
      q_valid <= load;
      if (load) begin
        q_expanded <= nxt_expanded;
        q_code     <= nxt_code;
        q_fits     <= nxt_fits;
      end
    end
  end
endmodule

// File: rtl/fpimm_codec.sv
`timescale 1ns/1ps
module fpimm_codec
  import fpimm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_dbl,
  input  logic [1:0]        in_op,
  input  logic [WORD_W-1:0] in_operand,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_expanded,
  output logic [CODE_W-1:0] out_code,
  output logic              out_fits
);
  localparam int NLANE = 2;

  logic [WORD_W-1:0] lane_exp  [NLANE];
  logic [CODE_W-1:0] lane_code [NLANE];
  logic              lane_fit  [NLANE];

  // lane 0 single, lane 1 double
  for (genvar p = 0; p < NLANE; p++) begin : g_lane
    localparam bit IS_DBL = (p == 1);
    localparam int LW     = IS_DBL ? WORD_W : SP_W;
    logic [LW-1:0] ex;
    fpimm_lane #(.DOUBLE(IS_DBL), .CODE_W(CODE_W)) u_lane (
      .word     (in_operand[LW-1:0]),
      .expanded (ex),
      .raw_code (lane_code[p]),
      .fits     (lane_fit[p])
    );
    assign lane_exp[p] = WORD_W'(ex);
  end

  // named internal events for the checker
  logic              cap_fire;
  logic              chk_pass;
  logic [CODE_W-1:0] raw_sel;
  logic [WORD_W-1:0] exp_sel;
  logic [CODE_W-1:0] code_sel;
  logic              fits_sel;

  assign cap_fire = in_valid;
  assign chk_pass = in_dbl ? lane_fit[1]  : lane_fit[0];
  assign raw_sel  = in_dbl ? lane_code[1] : lane_code[0];
  assign exp_sel  = in_dbl ? lane_exp[1]  : lane_exp[0];

  fpimm_select u_sel (
    .op       (in_op),
    .raw_code (raw_sel),
    .fits     (chk_pass),
    .code     (code_sel),
    .fits_out (fits_sel)
  );

  fpimm_outreg #(.WORD_W(WORD_W), .CODE_W(CODE_W)) u_reg (
    .clk          (clk),
    .rst          (rst),
    .load         (cap_fire),
    .nxt_expanded (exp_sel),
    .nxt_code     (code_sel),
    .nxt_fits     (fits_sel),
    .q_valid      (out_valid),
    .q_expanded   (out_expanded),
    .q_code       (out_code),
    .q_fits       (out_fits)
  );
endmodule

// File: rtl/fpimm_codec_chk.sv
`timescale 1ns/1ps
module fpimm_codec_chk
  import fpimm_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_dbl,
  input logic [1:0]        in_op,
  input logic [WORD_W-1:0] in_operand,
  input logic              out_valid,
  input logic [WORD_W-1:0] out_expanded,
  input logic [CODE_W-1:0] out_code,
  input logic              out_fits,
  input logic              cap_fire,
  input logic              chk_pass
);
  a_r11_valid_follows: assert property (@(posedge clk) disable iff (rst)
    cap_fire |=> out_valid);

  a_r11_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_expanded) && $stable(out_code) && $stable(out_fits)));

  a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_dbl) |=> (out_expanded[63:32] == 32'h0));

  a_r1_sign_seed: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_dbl) |=>
      ((out_expanded[31] == $past(in_operand[7])) && (out_expanded[30] != out_expanded[29])));

  a_r3_seed_flip: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_dbl) |=> (out_expanded[62] != out_expanded[61]));

  a_r10_expand_quiet: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_EXPAND) |=> (out_code == '0 && !out_fits));

  a_r8_fail_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op[1]) |=> (out_fits || out_code == '0));

  a_r9_fit_reported: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_COMPRESS) |=> (out_fits == $past(chk_pass)));
endmodule

bind fpimm_codec fpimm_codec_chk u_chk (.*);

// File: tb/sim_fpimm_codec.sv
`timescale 1ns/1ps
module sim_fpimm_codec;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_dbl = 1'b0;
  logic [1:0]  in_op = 2'd0;
  logic [63:0] in_operand = 64'h0;
  logic        out_valid;
  logic [63:0] out_expanded;
  logic [7:0]  out_code;
  logic        out_fits;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fpimm_codec u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_dbl(in_dbl), .in_op(in_op),
    .in_operand(in_operand), .out_valid(out_valid), .out_expanded(out_expanded),
    .out_code(out_code), .out_fits(out_fits)
  );

  // ---- behavioural reference ----
  function automatic logic [63:0] ref_expand(input bit dbl, input logic [7:0] c);
    logic [63:0] s, sd, t;
    s  = 64'(c[7]);
    sd = 64'(c[6]);
    t  = 64'(c[5:0]);
    if (dbl) ref_expand = (s << 63) | ((64'd256 - sd) << 54) | (t << 48);
    else     ref_expand = (s << 31) | ((64'd32 - sd) << 25) | (t << 19);
  endfunction

  function automatic bit ref_fits(input bit dbl, input logic [63:0] x);
    logic [63:0] y, e;
    if (dbl) begin
      e = (x >> 54) & 64'h1FF;
      ref_fits = ((x & 64'h0000_FFFF_FFFF_FFFF) == 0) && (e == 64'hFF || e == 64'h100);
    end else begin
      y = x & 64'hFFFF_FFFF;
      e = (y >> 25) & 64'h3F;
      ref_fits = ((y & 64'h7FFFF) == 0) && (e == 64'h1F || e == 64'h20);
    end
  endfunction

  function automatic logic [7:0] ref_raw(input bit dbl, input logic [63:0] x);
    int hi;
    hi = dbl ? 32 : 0;
    ref_raw = 8'((((x >> (31 + hi)) & 1) << 7) | (((x >> (29 + hi)) & 1) << 6)
                 | ((x >> (19 + (dbl ? 29 : 0))) & 63));
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one request, compared on the cycle its result is registered
  task automatic apply(input logic [1:0] op, input bit dbl, input logic [63:0] x,
                       input string tag);
    logic [7:0] ecode;
    bit efit, f;
    logic [7:0] raw;
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_dbl = dbl; in_operand = x;
    @(negedge clk);
    in_valid = 1'b0;
    f   = ref_fits(dbl, x);
    raw = ref_raw(dbl, x);
    case (op)
      2'd0:    begin ecode = 8'h0; efit = 1'b0; end
      2'd1:    begin ecode = raw;  efit = f;    end
      default: begin ecode = f ? raw : 8'h0; efit = f; end
    endcase
    check({tag, " R11 valid"}, 64'(out_valid), 64'd1);
    check({tag, " R13 expanded"}, out_expanded, ref_expand(dbl, x[7:0]));
    check({tag, " code"}, 64'(out_code), 64'(ecode));
    check({tag, " fits"}, 64'(out_fits), 64'(efit));
  endtask

  initial begin
    #500000;
    if (!done) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [63:0] last;
    repeat (3) @(negedge clk);
    check("R11 reset valid", 64'(out_valid), 64'd0);
    check("R11 reset expanded", out_expanded, 64'd0);
    check("R11 reset code", 64'(out_code), 64'd0);
    rst = 1'b0;

    // every code: expand then check round trip, both precisions
    for (int c = 0; c < 256; c++) begin
      // R1 R2 R10 R12: expand with junk in the upper half
      apply(2'd0, 1'b0, {32'hA5C3_9E17, 24'h5A5A5A, 8'(c)}, "R1 R2 R10 R12 sp expand");
      // R6 R4 R12: every expansion fits and returns its own code
      apply(2'd2, 1'b0, ref_expand(1'b0, 8'(c)) | 64'hFFFF_0000_0000_0000, "R4 R6 R12 sp roundtrip");
      check("R4 sp code back", 64'(out_code), 64'(c));
      apply(2'd0, 1'b1, {56'h0123_4567_89AB_CD, 8'(c)}, "R3 R10 dp expand");
      apply(2'd2, 1'b1, ref_expand(1'b1, 8'(c)), "R5 R7 dp roundtrip");
      check("R5 dp code back", 64'(out_code), 64'(c));
    end

    // R6 R8: each single fit condition broken alone
    apply(2'd2, 1'b0, 64'h3F80_0001, "R6 R8 sp tail");
    apply(2'd2, 1'b0, 64'h4780_0000, "R6 R8 sp run");
    apply(2'd2, 1'b0, 64'h7F80_0000, "R6 R8 sp seed");
    apply(2'd3, 1'b0, 64'h4780_0000, "R8 reserved op");
    // R7 R8: double
    apply(2'd2, 1'b1, 64'h3FF0_0000_0000_0001, "R7 R8 dp tail");
    apply(2'd2, 1'b1, 64'h40F0_0000_0000_0000, "R7 R8 dp run");
    apply(2'd2, 1'b1, 64'h7FF0_0000_0000_0000, "R7 R8 dp seed");
    // R9: compress gives raw fields even when not fitting
    apply(2'd1, 1'b0, 64'h4780_0000, "R9 sp compress nofit");
    check("R9 raw code", 64'(out_code), 64'h30);
    apply(2'd1, 1'b1, 64'h40F0_0000_0000_0000, "R9 dp compress nofit");
    apply(2'd1, 1'b0, 64'hFFFF_FFFF_3F80_0000, "R4 R12 sp compress 1.0");
    check("R4 code of 1.0", 64'(out_code), 64'h70);
    apply(2'd1, 1'b1, 64'hC004_0000_0000_0000, "R5 dp compress -2.5");
    check("R5 code of -2.5", 64'(out_code), 64'h84);

    // R11: outputs hold while idle, valid drops
    last = out_expanded;
    @(negedge clk);
    check("R11 idle valid", 64'(out_valid), 64'd0);
    check("R11 idle hold", out_expanded, last);
    // R11: reset during a request
    in_valid = 1'b1; in_op = 2'd2; in_operand = 64'h3F80_0000; rst = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b0;
    check("R11 reset wins valid", 64'(out_valid), 64'd0);
    check("R11 reset wins code", 64'(out_code), 64'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule